// File: doc/BRIEF.md
# Paged Management-to-Register Bridge

This block lets a host with only 16-bit management transactions reach a 32-bit internal register space. It sits behind an already-decoded management port: each transaction arrives as one request cycle carrying a direction, a 5-bit PHY address, a 5-bit register number and, for writes, a 16-bit value. On the far side it drives a plain register bus. That bus has a byte address, 32-bit write data, a write strobe, a read strobe and 32-bit read data.

The internal word address is split into three parts. The upper nine bits are a page, which the host loads through a dedicated management location (PHY 0x1F, register 0x10). The middle three bits pick one of the PHY addresses 0x10 to 0x17. The low four bits pick an even/odd register pair within that PHY: the even register holds data bits 15:0 and the odd register holds bits 31:16. A 32-bit write is done as the odd half first and then the even half. Only the even access starts the internal write, so the register always sees both halves together. A 32-bit read is done as the even half first and then the odd half. The even access fetches the whole word and keeps the upper half, so both halves come from the same instant.

Top module: `mdio_reg_bridge`

## Requirements
- R1: After reset the page is zero, no bus strobe is active, no read response is signalled, and a read of the page location returns 0x0000.
- R2: A management write to PHY 0x1F, register 0x10 loads bits 8:0 of the write value into the page. A read of that location returns the page zero-extended to 16 bits. Neither access raises either bus strobe.
- R3: Every internal access uses byte address {page, PHY[2:0], register[4:1], 2'b00}, which is 18 bits wide.
- R4: A write to an odd register (register bit 0 set) of PHY 0x10..0x17 only stores the value as the pending upper half. No bus strobe is raised.
- R5: A write to an even register of PHY 0x10..0x17 raises the bus write strobe in that same cycle. The write data is {pending upper half, written value}.
- R6: A read of an even register of PHY 0x10..0x17 raises the bus read strobe in that same cycle. The response carries bus read data bits 15:0 and stores bits 31:16 as a snapshot.
- R7: A read of an odd register of PHY 0x10..0x17 returns the snapshot from the last even read, whatever the bus read data is now. No bus strobe is raised.
- R8: An access to any other PHY address, or to PHY 0x1F at any register other than 0x10, raises no bus strobe. It leaves the page and the pending upper half unchanged, and a read of it returns 0xFFFF.
- R9: Each read request gives exactly one response-valid pulse in the following cycle, with the data in that cycle. Write requests give none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mgmt_req | input | 1 | One-cycle management transaction request |
| mgmt_wr | input | 1 | 1 = write, 0 = read |
| mgmt_phy | input | 5 | Management PHY address |
| mgmt_reg | input | 5 | Management register number |
| mgmt_wdata | input | 16 | Management write value |
| mgmt_rdata | output | 16 | Management read value, valid with mgmt_rvalid |
| mgmt_rvalid | output | 1 | Read response valid, one cycle after the request |
| bus_addr | output | 18 | Internal byte address |
| bus_wdata | output | 32 | Internal write data |
| bus_wr | output | 1 | Internal write strobe |
| bus_rd | output | 1 | Internal read strobe |
| bus_rdata | input | 32 | Internal read data, sampled while bus_rd is high |

## Verification
A wrong page shows at once on the upper nine address bits of the next internal access. It also shows on the page read-back one cycle after the read request. A corrupted pending upper half stays hidden until the next even write, where it appears in bus_wdata[31:16] in that same cycle. A bad snapshot shows only on the next odd-register read response. So the bench reads the odd half after the bus data has already changed. It also puts ignored accesses between a high-half write and its commit, so that stray state updates reach the ports.

// File: rtl/mdio_bridge_pkg.sv
package mdio_bridge_pkg;

  typedef enum logic [1:0] {
    ACC_NONE = 2'd0,
    ACC_PAGE = 2'd1,
    ACC_LOW  = 2'd2,
    ACC_HIGH = 2'd3
  } acc_kind_e;

  localparam int unsigned MB_PHY_W  = 5;
  localparam int unsigned MB_REG_W  = 5;
  localparam int unsigned MB_HALF_W = 16;
  localparam int unsigned MB_PAGE_W = 9;
  localparam int unsigned MB_SLOT_W = 3;

endpackage

// File: rtl/mdio_acc_decode.sv
module mdio_acc_decode
  import mdio_bridge_pkg::*;
#(
  parameter int unsigned PHY_W = MB_PHY_W,
  parameter int unsigned REG_W = MB_REG_W,
  parameter int unsigned SLOT_W = MB_SLOT_W,
  parameter logic [PHY_W-1:0] PAGE_PHY = 5'h1F,
  parameter logic [REG_W-1:0] PAGE_REG = 5'h10,
  parameter logic [PHY_W-1:0] DATA_PHY_BASE = 5'h10
) (
  input  logic [PHY_W-1:0]  phy,
  input  logic [REG_W-1:0]  regn,
  output acc_kind_e         kind,
  output logic [SLOT_W-1:0] slot,
  output logic [REG_W-2:0]  idx
);

  function automatic logic in_data_group(input logic [PHY_W-1:0] p);
    return p[PHY_W-1:SLOT_W] == DATA_PHY_BASE[PHY_W-1:SLOT_W];
  endfunction

  function automatic logic is_page_loc(input logic [PHY_W-1:0] p,
                                       input logic [REG_W-1:0] r);
    return (p == PAGE_PHY) && (r == PAGE_REG);
  endfunction

  always_comb begin
    if (is_page_loc(phy, regn)) begin
      kind = ACC_PAGE;
    end else if (in_data_group(phy)) begin
      kind = regn[0] ? ACC_HIGH : ACC_LOW;
    end else begin
      kind = ACC_NONE;
    end
  end

  assign slot = phy[SLOT_W-1:0];
  assign idx  = regn[REG_W-1:1];

endmodule

// File: rtl/mdio_page_reg.sv
module mdio_page_reg #(
  parameter int unsigned PAGE_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [PAGE_W-1:0] din,
  output logic [PAGE_W-1:0] page
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page <= '0;
    end else if (load) begin
      page <= din;
    end
  end

endmodule

// File: rtl/mdio_half_hold.sv
module mdio_half_hold #(
  parameter int unsigned HALF_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_hi_load,
  input  logic [HALF_W-1:0] wr_hi_din,
  input  logic              rd_hi_load,
  input  logic [HALF_W-1:0] rd_hi_din,
  output logic [HALF_W-1:0] wr_hi,
  output logic [HALF_W-1:0] rd_hi
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_hi <= '0;
    end else if (wr_hi_load) begin
      wr_hi <= wr_hi_din;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_hi <= '0;
    end else if (rd_hi_load) begin
      rd_hi <= rd_hi_din;
    end
  end

endmodule

// File: rtl/mdio_reg_bridge.sv
module mdio_reg_bridge
  import mdio_bridge_pkg::*;
#(
  parameter int unsigned PHY_W = MB_PHY_W,
  parameter int unsigned REG_W = MB_REG_W,
  parameter int unsigned HALF_W = MB_HALF_W,
  parameter int unsigned PAGE_W = MB_PAGE_W,
  parameter int unsigned SLOT_W = MB_SLOT_W,
  parameter logic [PHY_W-1:0] PAGE_PHY = 5'h1F,
  parameter logic [REG_W-1:0] PAGE_REG = 5'h10,
  parameter logic [PHY_W-1:0] DATA_PHY_BASE = 5'h10,
  localparam int unsigned IDX_W = REG_W - 1,
  localparam int unsigned WORD_W = PAGE_W + SLOT_W + IDX_W,
  localparam int unsigned ADDR_W = WORD_W + 2,
  localparam int unsigned DATA_W = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mgmt_req,
  input  logic              mgmt_wr,
  input  logic [PHY_W-1:0]  mgmt_phy,
  input  logic [REG_W-1:0]  mgmt_reg,
  input  logic [HALF_W-1:0] mgmt_wdata,
  output logic [HALF_W-1:0] mgmt_rdata,
  output logic              mgmt_rvalid,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  output logic              bus_wr,
  output logic              bus_rd,
  input  logic [DATA_W-1:0] bus_rdata
);

  localparam int unsigned PAD_W = HALF_W - PAGE_W;

  function automatic logic [ADDR_W-1:0] make_byte_addr(
    input logic [PAGE_W-1:0] pg,
    input logic [SLOT_W-1:0] sl,
    input logic [IDX_W-1:0]  ix
  );
    return {pg, sl, ix, 2'b00};
  endfunction

  function automatic logic [HALF_W-1:0] widen_page(input logic [PAGE_W-1:0] pg);
    return {{PAD_W{1'b0}}, pg};
  endfunction

  acc_kind_e           kind;
  logic [SLOT_W-1:0]   slot;
  logic [IDX_W-1:0]    idx;
  logic [PAGE_W-1:0]   page_q;
  logic [HALF_W-1:0]   wr_hi_q;
  logic [HALF_W-1:0]   rd_hi_q;
  logic [HALF_W-1:0]   rd_next;
  logic                rd_req;
  logic                wr_req;
  logic                evt_page_wr;
  logic                evt_hi_wr;
  logic                evt_bus_wr;
  logic                evt_bus_rd;
  logic [HALF_W-PAGE_W-1:0] unused_page_bits;
  logic                rvalid_q;
  logic [HALF_W-1:0]   rdata_q;

  assign unused_page_bits = mgmt_wdata[HALF_W-1:PAGE_W];

  mdio_acc_decode #(
    .PHY_W(PHY_W), .REG_W(REG_W), .SLOT_W(SLOT_W),
    .PAGE_PHY(PAGE_PHY), .PAGE_REG(PAGE_REG), .DATA_PHY_BASE(DATA_PHY_BASE)
  ) u_decode (
    .phy(mgmt_phy),
    .regn(mgmt_reg),
    .kind(kind),
    .slot(slot),
    .idx(idx)
  );

  assign rd_req      = mgmt_req && !mgmt_wr;
  assign wr_req      = mgmt_req && mgmt_wr;
  assign evt_page_wr = wr_req && (kind == ACC_PAGE);
  assign evt_hi_wr   = wr_req && (kind == ACC_HIGH);
  assign evt_bus_wr  = wr_req && (kind == ACC_LOW);
  assign evt_bus_rd  = rd_req && (kind == ACC_LOW);

  mdio_page_reg #(.PAGE_W(PAGE_W)) u_page (
    .clk(clk),
    .rst_n(rst_n),
    .load(evt_page_wr),
    .din(mgmt_wdata[PAGE_W-1:0]),
    .page(page_q)
  );

  mdio_half_hold #(.HALF_W(HALF_W)) u_hold (
    .clk(clk),
    .rst_n(rst_n),
    .wr_hi_load(evt_hi_wr),
    .wr_hi_din(mgmt_wdata),
    .rd_hi_load(evt_bus_rd),
    .rd_hi_din(bus_rdata[DATA_W-1:HALF_W]),
    .wr_hi(wr_hi_q),
    .rd_hi(rd_hi_q)
  );

  assign bus_addr  = make_byte_addr(page_q, slot, idx);
  assign bus_wdata = {wr_hi_q, mgmt_wdata};
  assign bus_wr    = evt_bus_wr;
  assign bus_rd    = evt_bus_rd;

  always_comb begin
    unique case (kind)
      ACC_PAGE: rd_next = widen_page(page_q);
      ACC_LOW:  rd_next = bus_rdata[HALF_W-1:0];
      ACC_HIGH: rd_next = rd_hi_q;
      default:  rd_next = '1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
    end else begin
      rvalid_q <= rd_req;
      if (rd_req) begin
        rdata_q <= rd_next;
      end
    end
  end

  assign mgmt_rvalid = rvalid_q;
  assign mgmt_rdata  = rdata_q;

endmodule

// File: rtl/mdio_bridge_chk.sv
module mdio_bridge_chk #(
  parameter int unsigned PHY_W = 5,
  parameter int unsigned REG_W = 5,
  parameter int unsigned HALF_W = 16,
  parameter int unsigned PAGE_W = 9,
  parameter int unsigned SLOT_W = 3,
  parameter logic [PHY_W-1:0] PAGE_PHY = 5'h1F,
  parameter logic [REG_W-1:0] PAGE_REG = 5'h10,
  parameter logic [PHY_W-1:0] DATA_PHY_BASE = 5'h10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mgmt_req,
  input logic              mgmt_wr,
  input logic [PHY_W-1:0]  mgmt_phy,
  input logic [REG_W-1:0]  mgmt_reg,
  input logic [HALF_W-1:0] mgmt_wdata,
  input logic [HALF_W-1:0] mgmt_rdata,
  input logic              mgmt_rvalid,
  input logic [PAGE_W-1:0] bus_page,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [HALF_W-1:0] bus_rdata_lo,
  input logic [PAGE_W-1:0] page_q,
  input logic [HALF_W-1:0] wr_hi_q,
  input logic [HALF_W-1:0] rd_hi_q
);

  logic data_phy;
  logic page_hit;
  logic rd_req;
  logic wr_req;

  assign data_phy = mgmt_phy[PHY_W-1:SLOT_W] == DATA_PHY_BASE[PHY_W-1:SLOT_W];
  assign page_hit = (mgmt_phy == PAGE_PHY) && (mgmt_reg == PAGE_REG);
  assign rd_req   = mgmt_req && !mgmt_wr;
  assign wr_req   = mgmt_req && mgmt_wr;

  p_page_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && page_hit) |=> page_q == $past(mgmt_wdata[PAGE_W-1:0]));

  p_page_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_req && page_hit) |=> $stable(page_q));

  p_page_nobus_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mgmt_req && page_hit) |-> (!bus_wr && !bus_rd));

  p_addr_page_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr || bus_rd) |-> bus_page == page_q);

  p_hi_latch_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && data_phy && mgmt_reg[0]) |=> wr_hi_q == $past(mgmt_wdata));

  p_hi_nobus_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && data_phy && mgmt_reg[0]) |-> (!bus_wr && !bus_rd));

  p_commit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && data_phy && !mgmt_reg[0]) |-> (bus_wr && !bus_rd));

  p_low_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |=> (mgmt_rvalid && mgmt_rdata == $past(bus_rdata_lo)));

  p_snapshot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && data_phy && mgmt_reg[0]) |=> mgmt_rdata == $past(rd_hi_q));

  p_ignore_nobus_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mgmt_req && !data_phy && !page_hit) |-> (!bus_wr && !bus_rd));

  p_ignore_ffff_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !data_phy && !page_hit) |=> mgmt_rdata == {HALF_W{1'b1}});

  p_resp_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> mgmt_rvalid);

  p_noresp_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> !mgmt_rvalid);

endmodule

bind mdio_reg_bridge mdio_bridge_chk #(
  .PHY_W(PHY_W), .REG_W(REG_W), .HALF_W(HALF_W), .PAGE_W(PAGE_W),
  .SLOT_W(SLOT_W), .PAGE_PHY(PAGE_PHY), .PAGE_REG(PAGE_REG),
  .DATA_PHY_BASE(DATA_PHY_BASE)
) u_chk (
  .clk(clk),
  .rst_n(rst_n),
  .mgmt_req(mgmt_req),
  .mgmt_wr(mgmt_wr),
  .mgmt_phy(mgmt_phy),
  .mgmt_reg(mgmt_reg),
  .mgmt_wdata(mgmt_wdata),
  .mgmt_rdata(mgmt_rdata),
  .mgmt_rvalid(mgmt_rvalid),
  .bus_page(bus_addr[ADDR_W-1 -: PAGE_W]),
  .bus_wr(bus_wr),
  .bus_rd(bus_rd),
  .bus_rdata_lo(bus_rdata[HALF_W-1:0]),
  .page_q(page_q),
  .wr_hi_q(wr_hi_q),
  .rd_hi_q(rd_hi_q)
);

// File: tb/tb_mdio_reg_bridge.sv
module tb_mdio_reg_bridge;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mgmt_req = 1'b0;
  logic        mgmt_wr = 1'b0;
  logic [4:0]  mgmt_phy = '0;
  logic [4:0]  mgmt_reg = '0;
  logic [15:0] mgmt_wdata = '0;
  logic [15:0] mgmt_rdata;
  logic        mgmt_rvalid;
  logic [17:0] bus_addr;
  logic [31:0] bus_wdata;
  logic        bus_wr;
  logic        bus_rd;
  logic [31:0] rd_model = 32'h0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [15:0] exp_q[$];
  string       tag_q[$];

  always #2 clk = ~clk;

  mdio_reg_bridge dut (
    .clk(clk),
    .rst_n(rst_n),
    .mgmt_req(mgmt_req),
    .mgmt_wr(mgmt_wr),
    .mgmt_phy(mgmt_phy),
    .mgmt_reg(mgmt_reg),
    .mgmt_wdata(mgmt_wdata),
    .mgmt_rdata(mgmt_rdata),
    .mgmt_rvalid(mgmt_rvalid),
    .bus_addr(bus_addr),
    .bus_wdata(bus_wdata),
    .bus_wr(bus_wr),
    .bus_rd(bus_rd),
    .bus_rdata(rd_model)
  );

  function automatic logic [17:0] exp_addr(input int pg, input int phy, input int rg);
    int word;
    word = pg * 128 + (phy - 16) * 16 + rg / 2;
    return 18'(word * 4);
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic mgmt_write(input logic [4:0] phy, input logic [4:0] rg,
                            input logic [15:0] d, input bit exp_wr,
                            input logic [17:0] ea, input logic [31:0] ed,
                            input string tag);
    @(negedge clk);
    mgmt_req = 1'b1; mgmt_wr = 1'b1; mgmt_phy = phy; mgmt_reg = rg; mgmt_wdata = d;
    #1;
    check(bus_wr == exp_wr, tag, 32'(bus_wr), 32'(exp_wr));
    check(bus_rd == 1'b0, tag, 32'(bus_rd), 32'h0);
    if (exp_wr) begin
      check(bus_addr == ea, tag, 32'(bus_addr), 32'(ea));
      check(bus_wdata == ed, tag, bus_wdata, ed);
    end
    @(negedge clk);
    mgmt_req = 1'b0;
  endtask

  task automatic mgmt_read(input logic [4:0] phy, input logic [4:0] rg,
                           input bit exp_rd, input logic [17:0] ea,
                           input logic [15:0] ed, input string tag);
    @(negedge clk);
    mgmt_req = 1'b1; mgmt_wr = 1'b0; mgmt_phy = phy; mgmt_reg = rg;
    exp_q.push_back(ed);
    tag_q.push_back(tag);
    #1;
    check(bus_rd == exp_rd, tag, 32'(bus_rd), 32'(exp_rd));
    check(bus_wr == 1'b0, tag, 32'(bus_wr), 32'h0);
    if (exp_rd) check(bus_addr == ea, tag, 32'(bus_addr), 32'(ea));
    @(negedge clk);
    mgmt_req = 1'b0;
  endtask

  // Scoreboard monitor: pops one expected value per response pulse (R9)
  always @(negedge clk) begin
    if (rst_n && mgmt_rvalid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R9 unexpected response", 32'(mgmt_rdata), 32'h0);
      end else begin
        logic [15:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(mgmt_rdata == e, t, 32'(mgmt_rdata), 32'(e));
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(mgmt_rvalid == 1'b0, "R1 rvalid in reset", 32'(mgmt_rvalid), 32'h0);
    check(!bus_wr && !bus_rd, "R1 strobes in reset", {30'h0, bus_wr, bus_rd}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    mgmt_read(5'h1F, 5'h10, 1'b0, '0, 16'h0000, "R1 page after reset");

    // R2: page load, 9 bits kept
    mgmt_write(5'h1F, 5'h10, 16'hFE5A, 1'b0, '0, '0, "R2 page write no bus");
    mgmt_read(5'h1F, 5'h10, 1'b0, '0, 16'h005A, "R2 page readback");

    // R4 then R5 with R3 address
    mgmt_write(5'h13, 5'h07, 16'hDEAD, 1'b0, '0, '0, "R4 high half no bus");
    mgmt_write(5'h13, 5'h06, 16'hBEEF, 1'b1, exp_addr(9'h05A, 5'h13, 6),
               32'hDEADBEEF, "R5 R3 commit write");

    // R8: ignored accesses leave pending half and page untouched
    mgmt_write(5'h05, 5'h07, 16'h1111, 1'b0, '0, '0, "R8 ignored phy write");
    mgmt_write(5'h1F, 5'h11, 16'h0000, 1'b0, '0, '0, "R8 ignored page-phy write");
    mgmt_write(5'h17, 5'h1E, 16'h0001, 1'b1, exp_addr(9'h05A, 5'h17, 30),
               32'hDEAD0001, "R8 R3 latch kept, top slot");
    mgmt_read(5'h1F, 5'h10, 1'b0, '0, 16'h005A, "R8 page kept");
    mgmt_read(5'h1F, 5'h11, 1'b0, '0, 16'hFFFF, "R8 page-phy other reg");
    mgmt_read(5'h00, 5'h00, 1'b0, '0, 16'hFFFF, "R8 low phy read");
    mgmt_read(5'h18, 5'h01, 1'b0, '0, 16'hFFFF, "R8 phy 0x18 read");

    // R6 / R7: snapshot
    rd_model = 32'hA5A5_1234;
    mgmt_read(5'h10, 5'h00, 1'b1, exp_addr(9'h05A, 5'h10, 0), 16'h1234, "R6 low read");
    rd_model = 32'h0F0F_0000;
    mgmt_read(5'h10, 5'h01, 1'b0, '0, 16'hA5A5, "R7 snapshot high");
    rd_model = 32'h7777_8888;
    mgmt_read(5'h15, 5'h0C, 1'b1, exp_addr(9'h05A, 5'h15, 12), 16'h8888, "R6 second low read");
    mgmt_read(5'h15, 5'h0D, 1'b0, '0, 16'h7777, "R7 second snapshot");

    // R3: all-ones page
    mgmt_write(5'h1F, 5'h10, 16'hFFFF, 1'b0, '0, '0, "R2 page all ones");
    mgmt_read(5'h1F, 5'h10, 1'b0, '0, 16'h01FF, "R2 page 9-bit readback");
    mgmt_write(5'h10, 5'h00, 16'h4242, 1'b1, exp_addr(9'h1FF, 5'h10, 0),
               32'hDEAD4242, "R3 max page address");

    // R9: back-to-back reads
    @(negedge clk);
    mgmt_req = 1'b1; mgmt_wr = 1'b0; mgmt_phy = 5'h1F; mgmt_reg = 5'h10;
    exp_q.push_back(16'h01FF); tag_q.push_back("R9 back-to-back first");
    @(negedge clk);
    mgmt_phy = 5'h02;
    exp_q.push_back(16'hFFFF); tag_q.push_back("R9 back-to-back second");
    @(negedge clk);
    mgmt_req = 1'b0;
    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R9 all responses seen", 32'(exp_q.size()), 32'h0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule